// File: doc/BRIEF.md
# Keyed Control-Bit Clear Unit

This unit sits next to a multi-channel timer's control register and adds three registers to its register window. A key register holds a single unlock flag. Software changes that flag by writing an 8-bit command into a field of the key register. A clear register turns each written 1 into a request to drop the matching control bit. The unit computes the new control word from the control value it currently observes. It then presents that word on a one-cycle update strobe, so the control register's owner applies it through its normal ordered update path. The same strobe carries a per-channel mask that marks the channels whose enable bit is being dropped. Those channels must stop exactly as they would on a direct control write.

The third register is a per-channel event status register. Each channel's event input sets its bit, and the bit stays set. Software clears bits by writing a mask that is ANDed into the register, so written zeros clear flags and written ones keep them. When an event and a status write land in the same cycle, the event wins.

Top module: `ctlclr_guard`

## Requirements
- R1: After reset the unlock flag is 0, every status bit is 0 and the update strobe is low.
- R2: A write to byte offset 0x38 whose bits [8:1] equal 0xAE sets the unlock flag. Bit 0 and bits above 8 of the write are not looked at.
- R3: A write to 0x38 whose bits [8:1] equal 0xEA clears the unlock flag. Any other command value leaves the flag as it was.
- R4: A write to byte offset 0x3C while the flag is set raises `ctrl_upd_valid` for exactly the next cycle. In that cycle `ctrl_upd_data` equals the `ctrl_cur` of the write cycle with every bit that was 1 in the written data forced to 0.
- R5: A write to 0x3C while the flag is clear produces no update strobe.
- R6: With each update strobe, `chan_stop[c]` is 1 exactly when the enable bit of channel c was 1 in `ctrl_cur` and that bit is being cleared. The enable bit of channel c is control bit 4*c.
- R7: A high `evt_in[c]` sets status bit c on the next clock edge, and the bit then stays set until software clears it.
- R8: A write to byte offset 0x34 replaces the status register with its bitwise AND with the written data.
- R9: If `evt_in[c]` is high in the same cycle as a status write that would clear bit c, bit c ends up set.
- R10: A read of 0x38 returns the unlock flag in bit 0 with all other bits 0. A read of 0x34 returns the status in its low bits. A read of 0x3C or of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ctrl_cur | input | 32 | Present value of the timer control register |
| ctrl_upd_valid | output | 1 | One-cycle strobe: apply `ctrl_upd_data` |
| ctrl_upd_data | output | 32 | New control word after the clear |
| chan_stop | output | 8 | Channels whose enable is dropped by this update |
| evt_in | input | 8 | Per-channel event inputs |

## Verification
The functions that can share a cycle are the status register's event set and its software AND-clear. The bench drives one channel's event in the same cycle as a status write of all zeros. It then expects that channel's bit to remain set while every other bit clears. A second overlap is a clear-register write in the cycle right after an unlock command. That write must already see the new flag and produce its update.

// File: rtl/ctlclr_pkg.sv
package ctlclr_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned KEY_W     = 8;
  localparam int unsigned KEY_LSB   = 1;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h3C;
  localparam logic [KEY_W-1:0]  KEY_OPEN = 8'hAE;
  localparam logic [KEY_W-1:0]  KEY_SHUT = 8'hEA;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_STAT,
    ACC_KEY,
    ACC_CLR
  } acc_e;
endpackage

// File: rtl/ctlclr_key.sv
module ctlclr_key
  import ctlclr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_cmd,
  output logic             unlocked
);
  logic open_q, open_d, open_en;

  always_comb begin
    open_en = 1'b0;
    open_d  = open_q;
    if (key_we) begin
      if (key_cmd == KEY_OPEN) begin
        open_en = 1'b1;
        open_d  = 1'b1;
      end else if (key_cmd == KEY_SHUT) begin
        open_en = 1'b1;
        open_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_q <= 1'b0;
    else if (open_en) open_q <= open_d;
  end

  assign unlocked = open_q;
endmodule

// File: rtl/ctlclr_clear.sv
module ctlclr_clear #(
  parameter int unsigned DW        = 32,
  parameter int unsigned NCH       = 8,
  parameter int unsigned CTRL_BITS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_we,
  input  logic           unlocked,
  input  logic [DW-1:0]  clr_mask,
  input  logic [DW-1:0]  ctrl_cur,
  output logic           upd_valid,
  output logic [DW-1:0]  upd_data,
  output logic [NCH-1:0] stop_mask
);
  logic           fire;
  logic [DW-1:0]  data_d, data_q;
  logic [NCH-1:0] stop_d, stop_q;
  logic           vld_q;

  assign fire   = clr_we & unlocked;
  assign data_d = ctrl_cur & ~clr_mask;

  for (genvar c = 0; c < NCH; c++) begin : g_stop
    assign stop_d[c] = ctrl_cur[c*CTRL_BITS] & clr_mask[c*CTRL_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      stop_q <= '0;
    end else if (fire) begin
      data_q <= data_d;
      stop_q <= stop_d;
    end
  end

  assign upd_valid = vld_q;
  assign upd_data  = data_q;
  assign stop_mask = vld_q ? stop_q : '0;
endmodule

// File: rtl/ctlclr_status.sv
module ctlclr_status #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           st_we,
  input  logic [NCH-1:0] st_keep,
  input  logic [NCH-1:0] evt,
  output logic [NCH-1:0] status
);
  logic [NCH-1:0] st_q, st_d;
  logic           st_en;

  always_comb begin
    st_en = st_we | (|evt);
    st_d  = st_q;
    if (st_we) st_d = st_d & st_keep;
    st_d = st_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign status = st_q;
endmodule

// File: rtl/ctlclr_guard.sv
module ctlclr_guard
  import ctlclr_pkg::*;
#(
  parameter int unsigned NCH       = 8,
  parameter int unsigned CTRL_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] ctrl_cur,
  output logic              ctrl_upd_valid,
  output logic [DATA_W-1:0] ctrl_upd_data,
  output logic [NCH-1:0]    chan_stop,
  input  logic [NCH-1:0]    evt_in
);
  localparam int unsigned PAD_W = DATA_W - NCH;

  acc_e           acc;
  logic           unlocked;
  logic [NCH-1:0] status;

  always_comb begin
    unique case (reg_addr)
      OFS_STAT: acc = ACC_STAT;
      OFS_KEY:  acc = ACC_KEY;
      OFS_CLR:  acc = ACC_CLR;
      default:  acc = ACC_NONE;
    endcase
  end

  ctlclr_key u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (reg_wr && acc == ACC_KEY),
    .key_cmd  (reg_wdata[KEY_LSB +: KEY_W]),
    .unlocked (unlocked)
  );

  ctlclr_clear #(.DW(DATA_W), .NCH(NCH), .CTRL_BITS(CTRL_BITS)) u_clr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_we    (reg_wr && acc == ACC_CLR),
    .unlocked  (unlocked),
    .clr_mask  (reg_wdata),
    .ctrl_cur  (ctrl_cur),
    .upd_valid (ctrl_upd_valid),
    .upd_data  (ctrl_upd_data),
    .stop_mask (chan_stop)
  );

  ctlclr_status #(.NCH(NCH)) u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_we   (reg_wr && acc == ACC_STAT),
    .st_keep (reg_wdata[NCH-1:0]),
    .evt     (evt_in),
    .status  (status)
  );

  always_comb begin
    unique case (acc)
      ACC_STAT: reg_rdata = {{PAD_W{1'b0}}, status};
      ACC_KEY:  reg_rdata = {{(DATA_W-1){1'b0}}, unlocked};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ctlclr_guard_chk.sv
module ctlclr_guard_chk
  import ctlclr_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] ctrl_cur,
  input logic              ctrl_upd_valid,
  input logic [DATA_W-1:0] ctrl_upd_data,
  input logic [NCH-1:0]    chan_stop,
  input logic [NCH-1:0]    evt_in,
  input logic              unlocked,
  input logic [NCH-1:0]    status
);
  logic key_wr, clr_wr;
  assign key_wr = reg_wr && reg_addr == OFS_KEY;
  assign clr_wr = reg_wr && reg_addr == OFS_CLR;

  p_open_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && reg_wdata[8:1] == 8'hAE |=> unlocked);

  p_shut_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && reg_wdata[8:1] == 8'hEA |=> !unlocked);

  p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_wr && (reg_wdata[8:1] == 8'hAE || reg_wdata[8:1] == 8'hEA))
    |=> $stable(unlocked));

  p_upd_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && unlocked |=> ctrl_upd_valid &&
      ctrl_upd_data == ($past(ctrl_cur) & ~$past(reg_wdata)));

  p_locked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_wr && unlocked) |=> !ctrl_upd_valid);

  p_stop_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_upd_valid |-> chan_stop == '0);

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_in |=> (status & $past(evt_in)) == $past(evt_in));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == OFS_STAT) |=> (status & $past(status)) == $past(status));
endmodule

bind ctlclr_guard ctlclr_guard_chk #(.NCH(NCH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_wr         (reg_wr),
  .reg_addr       (reg_addr),
  .reg_wdata      (reg_wdata),
  .ctrl_cur       (ctrl_cur),
  .ctrl_upd_valid (ctrl_upd_valid),
  .ctrl_upd_data  (ctrl_upd_data),
  .chan_stop      (chan_stop),
  .evt_in         (evt_in),
  .unlocked       (unlocked),
  .status         (status)
);

// File: tb/ctlclr_guard_test.sv
module ctlclr_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] ctrl_cur = '0;
  logic        ctrl_upd_valid;
  logic [31:0] ctrl_upd_data;
  logic [7:0]  chan_stop;
  logic [7:0]  evt_in = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ctlclr_guard uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_cur(ctrl_cur),
    .ctrl_upd_valid(ctrl_upd_valid), .ctrl_upd_data(ctrl_upd_data),
    .chan_stop(chan_stop), .evt_in(evt_in)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, edge captures, return at following negedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] exp_stop(logic [31:0] c, logic [31:0] m);
    logic [7:0] s;
    for (int k = 0; k < 8; k++) s[k] = c[4*k] & m[4*k];
    return s;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h38, d); check("R1 flag", d, 32'h0);
    rd(8'h34, d); check("R1 status", d, 32'h0);
    check("R1 strobe", {31'b0, ctrl_upd_valid}, 32'h0);
  endtask

  task automatic t_locked_clear();
    ctrl_cur = 32'hFFFF_FFFF;
    wr(8'h3C, 32'h0000_0001);
    check("R5 locked write", {31'b0, ctrl_upd_valid}, 32'h0);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    wr(8'h38, (32'hAE << 1) | 32'h0000_F001);
    rd(8'h38, d); check("R2 unlock", d, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] c, m;
    c = 32'h0F0F_1331; m = 32'h0000_0111;
    ctrl_cur = c;
    wr(8'h3C, m);
    check("R4 strobe", {31'b0, ctrl_upd_valid}, 32'h1);
    check("R4 data", ctrl_upd_data, c & ~m);
    check("R6 stop", {24'b0, chan_stop}, {24'b0, exp_stop(c, m)});
    @(negedge clk);
    check("R4 one cycle", {31'b0, ctrl_upd_valid}, 32'h0);
    check("R6 stop idle", {24'b0, chan_stop}, 32'h0);
    c = 32'h1111_0000; m = 32'h1010_FFFF;
    ctrl_cur = c;
    wr(8'h3C, m);
    check("R4 data 2", ctrl_upd_data, c & ~m);
    check("R6 stop 2", {24'b0, chan_stop}, {24'b0, exp_stop(c, m)});
  endtask

  task automatic t_commands();
    logic [31:0] d;
    wr(8'h38, 32'h55 << 1);
    rd(8'h38, d); check("R3 other cmd keeps", d, 32'h1);
    wr(8'h38, 32'hEA << 1);
    rd(8'h38, d); check("R3 lock", d, 32'h0);
    wr(8'h38, 32'hAE);
    rd(8'h38, d); check("R3 unshifted key ignored", d, 32'h0);
    ctrl_cur = 32'h0000_0011;
    wr(8'h3C, 32'h11);
    check("R5 after relock", {31'b0, ctrl_upd_valid}, 32'h0);
    // unlock then clear on the very next cycle
    reg_wr = 1'b1; reg_addr = 8'h38; reg_wdata = 32'hAE << 1;
    @(negedge clk);
    reg_addr = 8'h3C; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    check("R4 back-to-back", {31'b0, ctrl_upd_valid}, 32'h1);
    check("R4 back-to-back data", ctrl_upd_data, 32'h10);
  endtask

  task automatic t_status();
    logic [31:0] d;
    evt_in = 8'h05; @(negedge clk); evt_in = 8'h00;
    rd(8'h34, d); check("R7 set", d, 32'h05);
    evt_in = 8'h80; @(negedge clk); evt_in = 8'h00;
    @(negedge clk);
    rd(8'h34, d); check("R7 sticky", d, 32'h85);
    wr(8'h34, 32'hFFFF_FF7E);
    rd(8'h34, d); check("R8 and clear", d, 32'h04);
    evt_in = 8'h01;
    wr(8'h34, 32'h0);
    evt_in = 8'h00;
    rd(8'h34, d); check("R9 event wins", d, 32'h01);
  endtask

  task automatic t_reads();
    logic [31:0] d;
    rd(8'h3C, d); check("R10 clear reg reads 0", d, 32'h0);
    rd(8'h30, d); check("R10 unmapped reads 0", d, 32'h0);
    rd(8'h38, d); check("R10 flag only", d, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_clear();
    t_unlock();
    t_clear();
    t_commands();
    t_status();
    t_reads();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule